// File: doc/BRIEF.md
# Quaternary Macro Gate Sequencer

This block evaluates two reversible quaternary macro gates over GF(4). It does not compute them directly. It steps through a fixed list of primitive operations, one primitive per clock. There are two primitive kinds. The first is an unconditional one-digit transform on a single line: add a constant, or multiply by a constant. The second is a controlled transform, which changes its target line only while its control line holds the value 3. Because a control fires only at 3, every other control value is reached by rotating the control line with additive offsets, and the same offsets restore it afterwards.

Four 2-bit lines are held inside the block: A, B, C and a zero-initialised ancilla T. The controlled-sum macro leaves A unchanged and turns B into A+B. The controlled-product macro builds A·B on T in three segments. In segment j, line B is rotated so that it reads 3 only when B equals j. Line A is doubled between segments so that it carries j·A. A final controlled-sum segment then adds T into C. With the mirror option, the three product segments are replayed in reverse order, with each doubling replaced by a multiply by 3, so that T returns to 0.

The lines are visible on every clock, so the intermediate steps can be traced. When a macro ends, a reference evaluator compares the final lines with a direct GF(4) computation and raises a flag on any mismatch.

Top module: `qgf_macro_seq`

## Requirements
- R1: While reset is held and after it is released, busy, done, req_reject and chk_fail are 0, all four lines read 0 and steps_used is 0.
- R2: When req_valid is high and the block is idle, busy is high on the next cycle. Lines A, B and C then hold req_a, req_b and req_c, and the ancilla holds 0.
- R3: When req_valid is high while busy, req_reject is high in that same cycle. Such a request changes neither the running macro's lines, its step count nor its result. req_reject is low while idle.
- R4: A controlled-sum macro (req_kind=0) ends with line_a=A, line_b=A+B, line_c=C and ancilla 0. GF(4) addition is the bitwise XOR of the 2-bit codes.
- R5: A controlled-product macro (req_kind=1) ends with line_a=A, line_b=B and line_c=A·B+C. The GF(4) product uses these codes: 0 times anything is 0, 1 is the identity, 2·2=3, 2·3=1, 3·3=2.
- R6: After a controlled-product macro the ancilla reads 0 when MIRROR_EN=1 (the default) and A·B when MIRROR_EN=0.
- R7: One primitive is applied per clock. done rises exactly N cycles after the accepting edge, and steps_used then reads N. N is 6 for the controlled-sum macro, 54 for the controlled-product macro with mirror and 30 without.
- R8: The first step of a controlled-sum macro adds 2 to line A, so line_a reads A XOR 2. During any macro at most one line changes per clock.
- R9: A controlled primitive whose control line is not 3 leaves every line unchanged. For example, the second controlled-sum step changes line B (by +1) only when A=1.
- R10: done is a one-cycle pulse, busy is low while done is high, and chk_fail is 0 after every macro.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Macro request strobe |
| req_kind | input | 1 | 0 = controlled sum, 1 = controlled product |
| req_a | input | DIGIT_W | Initial value of line A |
| req_b | input | DIGIT_W | Initial value of line B |
| req_c | input | DIGIT_W | Initial value of line C |
| req_reject | output | 1 | Request seen while busy and dropped |
| busy | output | 1 | A macro is being stepped |
| line_a | output | DIGIT_W | Current value of line A |
| line_b | output | DIGIT_W | Current value of line B |
| line_c | output | DIGIT_W | Current value of line C |
| line_anc | output | DIGIT_W | Current value of the ancilla |
| done | output | 1 | One-cycle pulse when a macro has finished |
| steps_used | output | STEP_W | Primitive count of the last finished macro |
| chk_fail | output | 1 | Final lines differed from direct GF(4) evaluation |

## Verification
The hardest situation to reach from the ports is a request that arrives in the middle of a long controlled-product run. It has to leave the run intact, even though the same request would start a new macro one cycle after done. The stimulus places a request with different operand values on req_valid at a fixed step of a running product macro. It then checks the reject strobe, the unchanged latency and the final values. Rotated controls that must not fire are reached by running every operand combination of both macros. The bench also traces the first two controlled-sum steps, which shows both the additive offset on A and a controlled step that either fires or holds.

// File: rtl/qgf_pkg.sv
package qgf_pkg;

   typedef logic [1:0] gf4_t;
   typedef logic [3:0][1:0] lines_t;

   typedef enum logic [1:0] {LN_A = 2'd0, LN_B = 2'd1, LN_C = 2'd2, LN_T = 2'd3} line_sel_e;
   typedef enum logic {XF_ADD = 1'b0, XF_MUL = 1'b1} xform_e;
   typedef enum logic {MAC_FEYN = 1'b0, MAC_TOFF = 1'b1} macro_e;

   localparam gf4_t CTL_FIRE = 2'd3;

   typedef struct packed {
      logic      ctl_en;
      line_sel_e ctl;
      line_sel_e tgt;
      xform_e    xf;
      gf4_t      k;
   } prim_t;

   function automatic gf4_t gf4_add(gf4_t x, gf4_t y);
      return x ^ y;
   endfunction

   // polynomial product reduced by x^2 = x + 1
   function automatic gf4_t gf4_mul(gf4_t x, gf4_t y);
      gf4_t p;
      p[1] = (x[1] & y[1]) ^ (x[1] & y[0]) ^ (x[0] & y[1]);
      p[0] = (x[1] & y[1]) ^ (x[0] & y[0]);
      return p;
   endfunction

endpackage

// File: rtl/qgf_prim_rom.sv
module qgf_prim_rom
   import qgf_pkg::*;
#(
   parameter bit MIRROR_EN = 1'b1,
   parameter int STEP_W    = 6
) (
   input  macro_e            kind_i,
   input  logic [STEP_W-1:0] step_i,
   output prim_t             prim_o,
   output logic              last_o
);

   localparam int SUM_N  = 6;
   localparam int SEG_N  = 8;
   localparam int FWD_N  = 3 * SEG_N;
   localparam int PROD_N = FWD_N + SUM_N + (MIRROR_EN ? FWD_N : 0);

   // control rotation offsets: cumulative 2, 2^3=1, 1^1=0
   function automatic gf4_t rot_off(int i);
      case (i)
         0:       return 2'd2;
         1:       return 2'd3;
         default: return 2'd1;
      endcase
   endfunction

   // controlled-sum macro: rotate control, then controlled +1/+2/+3 on target
   function automatic prim_t sum_prim(line_sel_e c, line_sel_e t, int i);
      prim_t p;
      p.ctl = c;
      p.xf  = XF_ADD;
      if (i % 2 == 0) begin
         p.ctl_en = 1'b0;
         p.tgt    = c;
         p.k      = rot_off(i / 2);
      end else begin
         p.ctl_en = 1'b1;
         p.tgt    = t;
         p.k      = gf4_t'(i / 2 + 1);
      end
      return p;
   endfunction

   // product segment step; scale_k doubles A forward, triples it on replay
   function automatic prim_t seg_prim(int f, gf4_t scale_k);
      prim_t p;
      int    seg;
      int    r;
      seg      = f / SEG_N;
      r        = f % SEG_N;
      p.ctl_en = 1'b0;
      p.ctl    = LN_B;
      p.tgt    = LN_A;
      p.xf     = XF_ADD;
      p.k      = 2'd0;
      case (r)
         0: begin
            p.tgt = LN_B;
            p.k   = rot_off(seg);
         end
         1, 3, 5: begin
            p.ctl_en = 1'b1;
            p.ctl    = LN_B;
            p.tgt    = LN_A;
            p.k      = rot_off((r - 1) / 2);
         end
         2, 4, 6: begin
            p.ctl_en = 1'b1;
            p.ctl    = LN_A;
            p.tgt    = LN_T;
            p.k      = gf4_t'(r / 2);
         end
         default: begin
            p.xf  = XF_MUL;
            p.tgt = LN_A;
            p.k   = scale_k;
         end
      endcase
      return p;
   endfunction

   int s_idx;

   always_comb begin
      s_idx = int'(step_i);
      if (kind_i == MAC_FEYN) begin
         prim_o = sum_prim(LN_A, LN_B, s_idx);
         last_o = (s_idx == SUM_N - 1);
      end else begin
         last_o = (s_idx == PROD_N - 1);
         if (s_idx < FWD_N)
            prim_o = seg_prim(s_idx, 2'd2);
         else if (s_idx < FWD_N + SUM_N)
            prim_o = sum_prim(LN_T, LN_C, s_idx - FWD_N);
         else
            prim_o = seg_prim(PROD_N - 1 - s_idx, 2'd3);
      end
   end

endmodule

// File: rtl/qgf_prim_exec.sv
module qgf_prim_exec
   import qgf_pkg::*;
(
   input  lines_t lines_i,
   input  prim_t  prim_i,
   output lines_t lines_o
);

   logic fire;

   always_comb begin
      lines_o = lines_i;
      fire    = !prim_i.ctl_en || (lines_i[prim_i.ctl] == CTL_FIRE);
      if (fire) begin
         if (prim_i.xf == XF_ADD)
            lines_o[prim_i.tgt] = gf4_add(lines_i[prim_i.tgt], prim_i.k);
         else
            lines_o[prim_i.tgt] = gf4_mul(lines_i[prim_i.tgt], prim_i.k);
      end
   end

endmodule

// File: rtl/qgf_ref_eval.sv
module qgf_ref_eval
   import qgf_pkg::*;
#(
   parameter bit MIRROR_EN = 1'b1
) (
   input  macro_e kind_i,
   input  gf4_t   a_i,
   input  gf4_t   b_i,
   input  gf4_t   c_i,
   output lines_t exp_o
);

   gf4_t prod;
   gf4_t anc_left;

   assign prod = gf4_mul(a_i, b_i);

   generate
      if (MIRROR_EN) begin : g_uncompute
         assign anc_left = '0;
      end else begin : g_keep
         assign anc_left = prod;
      end
   endgenerate

   always_comb begin
      if (kind_i == MAC_FEYN)
         exp_o = {2'd0, c_i, gf4_add(a_i, b_i), a_i};
      else
         exp_o = {anc_left, gf4_add(prod, c_i), b_i, a_i};
   end

endmodule

// File: rtl/qgf_macro_seq.sv
module qgf_macro_seq
   import qgf_pkg::*;
#(
   parameter bit  MIRROR_EN = 1'b1,
   parameter int  DIGIT_W   = 2,
   localparam int MAX_STEPS = MIRROR_EN ? 54 : 30,
   localparam int STEP_W    = $clog2(MAX_STEPS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_kind,
   input  logic [DIGIT_W-1:0] req_a,
   input  logic [DIGIT_W-1:0] req_b,
   input  logic [DIGIT_W-1:0] req_c,
   output logic               req_reject,
   output logic               busy,
   output logic [DIGIT_W-1:0] line_a,
   output logic [DIGIT_W-1:0] line_b,
   output logic [DIGIT_W-1:0] line_c,
   output logic [DIGIT_W-1:0] line_anc,
   output logic               done,
   output logic [STEP_W-1:0]  steps_used,
   output logic               chk_fail
);

   generate
      if (DIGIT_W != 2) begin : g_bad_width
         initial $error("qgf_macro_seq: DIGIT_W must be 2 for GF(4)");
      end
   endgenerate

   lines_t            lines_q, lines_nx, exp_lines;
   logic [STEP_W-1:0] step_q, steps_q;
   logic              busy_q, done_q, chk_q, last;
   macro_e            kind_q;
   gf4_t              orig_a_q, orig_b_q, orig_c_q;
   prim_t             prim;

   qgf_prim_rom #(.MIRROR_EN(MIRROR_EN), .STEP_W(STEP_W)) u_rom (
      .kind_i (kind_q),
      .step_i (step_q),
      .prim_o (prim),
      .last_o (last)
   );

   qgf_prim_exec u_exec (
      .lines_i (lines_q),
      .prim_i  (prim),
      .lines_o (lines_nx)
   );

   qgf_ref_eval #(.MIRROR_EN(MIRROR_EN)) u_ref (
      .kind_i (kind_q),
      .a_i    (orig_a_q),
      .b_i    (orig_b_q),
      .c_i    (orig_c_q),
      .exp_o  (exp_lines)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lines_q  <= '0;
         step_q   <= '0;
         steps_q  <= '0;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         chk_q    <= 1'b0;
         kind_q   <= MAC_FEYN;
         orig_a_q <= '0;
         orig_b_q <= '0;
         orig_c_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               lines_q  <= {2'd0, req_c, req_b, req_a};
               kind_q   <= macro_e'(req_kind);
               orig_a_q <= req_a;
               orig_b_q <= req_b;
               orig_c_q <= req_c;
               step_q   <= '0;
               busy_q   <= 1'b1;
            end
         end else begin
            lines_q <= lines_nx;
            step_q  <= step_q + 1'b1;
            if (last) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               steps_q <= step_q + 1'b1;
               chk_q   <= (lines_nx != exp_lines);
            end
         end
      end
   end

   assign req_reject = req_valid & busy_q;
   assign busy       = busy_q;
   assign done       = done_q;
   assign steps_used = steps_q;
   assign chk_fail   = chk_q;
   assign line_a     = lines_q[LN_A];
   assign line_b     = lines_q[LN_B];
   assign line_c     = lines_q[LN_C];
   assign line_anc   = lines_q[LN_T];

   // ---------------- assertions ----------------
   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy_q) |=> (busy_q && lines_q[LN_T] == 2'd0 && lines_q[LN_A] == $past(req_a)));

   assert_hold_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && req_valid) |=> (kind_q == $past(kind_q) && orig_a_q == $past(orig_a_q)
                                 && orig_b_q == $past(orig_b_q) && orig_c_q == $past(orig_c_q)));

   assert_ctl_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && kind_q == MAC_FEYN) |-> (lines_q[LN_A] == orig_a_q));

   assert_line_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && kind_q == MAC_TOFF) |-> (lines_q[LN_A] == orig_a_q && lines_q[LN_B] == orig_b_q));

   assert_step_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last) |=> (busy_q && step_q == $past(step_q) + 1'b1));

   assert_one_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> ($countones({lines_q[LN_A] != $past(lines_q[LN_A]),
                              lines_q[LN_B] != $past(lines_q[LN_B]),
                              lines_q[LN_C] != $past(lines_q[LN_C]),
                              lines_q[LN_T] != $past(lines_q[LN_T])}) <= 1));

   assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && prim.ctl_en && lines_q[prim.ctl] != CTL_FIRE) |=> (lines_q == $past(lines_q)));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   assert_done_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && !chk_q));

endmodule

// File: tb/qgf_macro_seq_tb.sv
module qgf_macro_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam bit MIRROR     = 1'b1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_kind = 1'b0;
   logic [1:0] req_a = '0, req_b = '0, req_c = '0;
   logic       req_reject, busy, done, chk_fail;
   logic [1:0] line_a, line_b, line_c, line_anc;
   logic [5:0] steps_used;

   int total = 0;
   int bad   = 0;

   typedef struct {
      bit         kind;
      logic [1:0] a, b, c, t;
      int         steps;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   qgf_macro_seq #(.MIRROR_EN(MIRROR)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_kind   (req_kind),
      .req_a      (req_a),
      .req_b      (req_b),
      .req_c      (req_c),
      .req_reject (req_reject),
      .busy       (busy),
      .line_a     (line_a),
      .line_b     (line_b),
      .line_c     (line_c),
      .line_anc   (line_anc),
      .done       (done),
      .steps_used (steps_used),
      .chk_fail   (chk_fail)
   );

   // GF(4) product from the code table stated in R5
   function automatic logic [1:0] ref_mul(logic [1:0] x, logic [1:0] y);
      if (x == 0 || y == 0) return 2'd0;
      if (x == 1) return y;
      if (y == 1) return x;
      if (x == y) return (x == 2) ? 2'd3 : 2'd2;
      return 2'd1;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: issue one macro, push expectation, trace latency
   task automatic run_macro(bit kind, logic [1:0] a, logic [1:0] b, logic [1:0] c, bit intrude);
      exp_t e;
      int   k;
      e.kind = kind;
      e.a    = a;
      e.b    = b;
      if (kind == 1'b0) begin
         e.b     = a ^ b;
         e.c     = c;
         e.t     = 2'd0;
         e.steps = 6;
      end else begin
         e.c     = ref_mul(a, b) ^ c;
         e.t     = MIRROR ? 2'd0 : ref_mul(a, b);
         e.steps = MIRROR ? 54 : 30;
      end
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = kind;
      req_a     = a;
      req_b     = b;
      req_c     = c;
      #1;
      chk(req_reject == 1'b0, "R3", "reject while idle", int'(req_reject), 0);
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1 && line_a == a && line_b == b && line_c == c && line_anc == 2'd0,
          "R2", "loaded lines", {busy, line_a, line_b, line_c, line_anc},
          {1'b1, a, b, c, 2'd0});
      k = 0;
      while (!done && k < 200) begin
         @(negedge clk);
         k++;
         if (kind == 1'b0 && k == 1)
            chk(line_a == (a ^ 2'd2) && line_b == b, "R8", "first step on A",
                {line_a, line_b}, {a ^ 2'd2, b});
         if (kind == 1'b0 && k == 2)
            chk(line_b == ((a == 2'd1) ? (b ^ 2'd1) : b), "R9", "gated second step",
                int'(line_b), int'((a == 2'd1) ? (b ^ 2'd1) : b));
         if (intrude && k == 5) begin
            req_valid = 1'b1;
            req_kind  = ~kind;
            req_a     = ~a;
            req_b     = ~b;
            req_c     = ~c;
            #1;
            chk(req_reject == 1'b1, "R3", "reject while busy", int'(req_reject), 1);
         end
         if (intrude && k == 6)
            req_valid = 1'b0;
      end
      chk(k == e.steps, "R7", "latency to done", k, e.steps);
      chk(busy == 1'b0, "R10", "busy low at done", int'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
   endtask

   // monitor: pop expectation on every done pulse
   initial begin
      exp_t e;
      string rq;
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
               e  = sb.pop_front();
               rq = e.kind ? "R5" : "R4";
               chk(line_a == e.a, rq, "line_a", int'(line_a), int'(e.a));
               chk(line_b == e.b, rq, "line_b", int'(line_b), int'(e.b));
               chk(line_c == e.c, rq, "line_c", int'(line_c), int'(e.c));
               chk(line_anc == e.t, e.kind ? "R6" : "R4", "ancilla", int'(line_anc), int'(e.t));
               chk(int'(steps_used) == e.steps, "R7", "steps_used", int'(steps_used), e.steps);
               chk(chk_fail == 1'b0, "R10", "self-check flag", int'(chk_fail), 0);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      chk(1'b0, "R7", "watchdog expired", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && chk_fail == 0 && req_reject == 0, "R1", "flags in reset",
          {busy, done, chk_fail, req_reject}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({line_a, line_b, line_c, line_anc} == 8'd0 && steps_used == 0 && busy == 0,
          "R1", "state after reset", {line_a, line_b, line_c, line_anc, steps_used}, 0);
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            run_macro(1'b0, 2'(a), 2'(b), 2'(3 - a), 1'b0);
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               run_macro(1'b1, 2'(a), 2'(b), 2'(c), 1'b0);
      run_macro(1'b1, 2'd3, 2'd2, 2'd1, 1'b1);
      run_macro(1'b0, 2'd2, 2'd3, 2'd0, 1'b0);
      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R7", "all results seen", sb.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule